// File: doc/BRIEF.md
# Master Clock Selector with PLL Fallback

This block chooses the reference that paces the master clock domain of a chip. There are four candidate references: a slow clock, a main clock and two PLLs. The block divides the chosen one by a power of two. All four references reach the block as one-cycle ticks in a common fast system clock domain. The block turns the ticks of the effective reference into a single-cycle clock-enable pulse train. It never gates a clock. Every input is assumed to be synchronous to the system clock.

Software writes a source field, a prescaler field and an interrupt enable in a single write. The ready flag drops whenever the source or the prescaler changes. It rises again after four ticks of the effective reference, which models the resynchronization delay. The expected sequence is to change the source, wait for ready, then change the prescaler and wait for ready again. The block also watches the two PLL lock inputs. If the selected PLL loses lock, the block moves to a safe reference on its own: PLL A falls back to the slow clock and PLL B falls back to the main clock. Ready stays low until lock returns and the original PLL has settled again.

Top module: `mclk_selector`

## Requirements
- R1: The source field encodes 0 as slow clock, 1 as main clock, 2 as PLL A and 3 as PLL B. `effSrc` reports the reference currently in use in the same encoding, and `srcTick[i]` is the tick of source i.
- R2: Prescaler code c from 0 to 6 divides by 2^c, and code 7 divides by 1. `clkEn` is a one-cycle pulse issued once per N ticks of the effective reference. It appears one cycle after the tick that completes the count.
- R3: A write that changes the source or the prescaler clears `ready` on its own clock edge. `ready` rises on the edge that samples the 4th tick of the effective reference after that write, so ticks of any other source do not advance it.
- R4: A write whose source and prescaler equal the current ones leaves `ready` high and leaves the pulse rate unchanged.
- R5: While PLL A is selected and `pllALock` is low, the effective reference is the slow clock, `clkEn` follows slow ticks only, and `ready` stays low.
- R6: While PLL B is selected and `pllBLock` is low, the effective reference is the main clock and `ready` stays low.
- R7: When the lock of the selected PLL returns, `effSrc` goes back to that PLL on the next edge. `ready` rises after 4 ticks of the PLL.
- R8: A loss of lock on a PLL that is not selected has no effect on `ready` or `effSrc`.
- R9: `irq` equals `ready` AND the interrupt enable. Every write loads the interrupt enable from `wrIrqEn`.
- R10: After reset the source is the slow clock, the prescaler is divide by 1, `ready` is high and the interrupt enable is cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast system clock |
| rstN | input | 1 | Active-low synchronous reset |
| srcTick | input | 4 | Per-source reference ticks (bit i = source i) |
| wrEn | input | 1 | Configuration write strobe |
| wrSrc | input | 2 | Source field of the write |
| wrPres | input | 3 | Prescaler code of the write |
| wrIrqEn | input | 1 | Interrupt enable of the write |
| pllALock | input | 1 | PLL A lock indication |
| pllBLock | input | 1 | PLL B lock indication |
| clkEn | output | 1 | Divided master clock enable pulse |
| ready | output | 1 | Master clock settled |
| irq | output | 1 | Ready interrupt |
| effSrc | output | 2 | Reference currently in use |

## Verification
The hardest state to reach from the ports is a fallback. In it the slow or main clock has already finished settling, yet ready must still stay low because the selected PLL is unlocked. Once lock returns, the settle delay has to restart and count the ticks of the PLL. The bench first selects a PLL and waits for ready. It then drops lock and masks every tick except the fallback source's, so it can tell from the pulse count which reference is in use. It holds this state well past the settle time. Finally it raises lock and times the return of ready edge by edge. Separate masked and sparse tick patterns show that the settle delay counts ticks of the effective reference only.

// File: rtl/mclk_pkg.sv
package mclk_pkg;

  typedef enum logic [1:0] {
    SRC_SLOW = 2'd0,
    SRC_MAIN = 2'd1,
    SRC_PLLA = 2'd2,
    SRC_PLLB = 2'd3
  } srcSel_e;

  typedef struct packed {
    logic settleStart;
    logic divClear;
  } ctrlStrb_t;

endpackage

// File: rtl/mclk_ctrl.sv
module mclk_ctrl
  import mclk_pkg::*;
#(
  parameter int PRES_W = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [1:0]        wrSrc,
  input  logic [PRES_W-1:0] wrPres,
  input  logic              wrIrqEn,
  input  logic              pllALock,
  input  logic              pllBLock,
  input  logic              settleIdle,
  output ctrlStrb_t         strb,
  output logic [PRES_W-1:0] cfgPres,
  output srcSel_e           effSrc,
  output logic              ready,
  output logic              irqEn
);

  srcSel_e           cfgSrc;
  srcSel_e           srcNext;
  srcSel_e           effNext;
  logic [PRES_W-1:0] presNext;
  logic              cfgChange;
  logic              lostNext;
  logic              settleStart;
  logic              readyNext;

  function automatic srcSel_e pickEffective(input srcSel_e sel, input logic lockA,
                                            input logic lockB);
    srcSel_e res;
    res = sel;
    if (sel == SRC_PLLA && !lockA) res = SRC_SLOW;
    if (sel == SRC_PLLB && !lockB) res = SRC_MAIN;
    return res;
  endfunction

  always_comb begin
    srcNext   = wrEn ? srcSel_e'(wrSrc) : cfgSrc;
    presNext  = wrEn ? wrPres : cfgPres;
    cfgChange = wrEn && ((srcSel_e'(wrSrc) != cfgSrc) || (wrPres != cfgPres));
    effNext   = pickEffective(srcNext, pllALock, pllBLock);
    lostNext  = (srcNext == SRC_PLLA && !pllALock) || (srcNext == SRC_PLLB && !pllBLock);
    settleStart = cfgChange || (effNext != effSrc);
    readyNext   = !settleStart && !lostNext && settleIdle;
  end

  always_comb begin
    strb.settleStart = settleStart;
    strb.divClear    = settleStart;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cfgSrc  <= SRC_SLOW;
      cfgPres <= '0;
      effSrc  <= SRC_SLOW;
      ready   <= 1'b1;
      irqEn   <= 1'b0;
    end else begin
      cfgSrc  <= srcNext;
      cfgPres <= presNext;
      effSrc  <= effNext;
      ready   <= readyNext;
      if (wrEn) irqEn <= wrIrqEn;
    end
  end

  // R3
  readyDropChk: assert property (@(posedge clk) disable iff (!rstN)
    wrEn && ((srcSel_e'(wrSrc) != cfgSrc) || (wrPres != cfgPres)) |=> !ready);

  // R5
  fallbackAChk: assert property (@(posedge clk) disable iff (!rstN)
    !wrEn && cfgSrc == SRC_PLLA && !pllALock |=> (effSrc == SRC_SLOW) && !ready);

  // R6
  fallbackBChk: assert property (@(posedge clk) disable iff (!rstN)
    !wrEn && cfgSrc == SRC_PLLB && !pllBLock |=> (effSrc == SRC_MAIN) && !ready);

  // R8
  otherPllChk: assert property (@(posedge clk) disable iff (!rstN)
    !wrEn && (cfgSrc == SRC_SLOW || cfgSrc == SRC_MAIN) |=> effSrc == $past(cfgSrc));

endmodule

// File: rtl/mclk_datapath.sv
module mclk_datapath
  import mclk_pkg::*;
#(
  parameter int PRES_W       = 3,
  parameter int MAX_CODE     = 6,
  parameter int SETTLE_TICKS = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [3:0]        srcTick,
  input  srcSel_e           effSrc,
  input  logic [PRES_W-1:0] cfgPres,
  input  ctrlStrb_t         strb,
  output logic              clkEn,
  output logic              settleIdle
);

  localparam int CNT_W   = (MAX_CODE > 0) ? MAX_CODE : 1;
  localparam int SET_W   = $clog2(SETTLE_TICKS + 1);
  localparam int N_CODES = 2 ** PRES_W;

  logic             tick;
  logic [CNT_W-1:0] divCnt;
  logic [CNT_W-1:0] lastSel;
  logic [CNT_W-1:0] lastTbl [N_CODES];
  logic [SET_W-1:0] settleCnt;

  for (genvar g = 0; g < N_CODES; g++) begin : gLast
    localparam int LAST_V = (g <= MAX_CODE) ? ((1 << g) - 1) : 0;
    assign lastTbl[g] = CNT_W'(LAST_V);
  end

  assign tick       = srcTick[effSrc];
  assign lastSel    = lastTbl[cfgPres];
  assign settleIdle = (settleCnt == '0) || (settleCnt == SET_W'(1) && tick);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      settleCnt <= '0;
    end else if (strb.settleStart) begin
      settleCnt <= SET_W'(SETTLE_TICKS);
    end else if (tick && settleCnt != '0) begin
      settleCnt <= settleCnt - SET_W'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      divCnt <= '0;
      clkEn  <= 1'b0;
    end else if (strb.divClear) begin
      divCnt <= '0;
      clkEn  <= 1'b0;
    end else if (tick) begin
      if (divCnt >= lastSel) begin
        divCnt <= '0;
        clkEn  <= 1'b1;
      end else begin
        divCnt <= divCnt + CNT_W'(1);
        clkEn  <= 1'b0;
      end
    end else begin
      clkEn <= 1'b0;
    end
  end

  // R2
  divLimitChk: assert property (@(posedge clk) disable iff (!rstN)
    divCnt <= lastSel);

  // R2
  singlePulseChk: assert property (@(posedge clk) disable iff (!rstN)
    clkEn && lastSel != '0 |=> !clkEn);

  // R3
  settleHoldChk: assert property (@(posedge clk) disable iff (!rstN)
    !tick && !strb.settleStart |=> $stable(settleCnt));

endmodule

// File: rtl/mclk_selector.sv
module mclk_selector
  import mclk_pkg::*;
#(
  parameter int PRES_W       = 3,
  parameter int MAX_CODE     = 6,
  parameter int SETTLE_TICKS = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [3:0]        srcTick,
  input  logic              wrEn,
  input  logic [1:0]        wrSrc,
  input  logic [PRES_W-1:0] wrPres,
  input  logic              wrIrqEn,
  input  logic              pllALock,
  input  logic              pllBLock,
  output logic              clkEn,
  output logic              ready,
  output logic              irq,
  output logic [1:0]        effSrc
);

  ctrlStrb_t         strb;
  srcSel_e           effSel;
  logic [PRES_W-1:0] cfgPres;
  logic              settleIdle;
  logic              irqEn;

  mclk_ctrl #(.PRES_W(PRES_W)) i_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .wrEn       (wrEn),
    .wrSrc      (wrSrc),
    .wrPres     (wrPres),
    .wrIrqEn    (wrIrqEn),
    .pllALock   (pllALock),
    .pllBLock   (pllBLock),
    .settleIdle (settleIdle),
    .strb       (strb),
    .cfgPres    (cfgPres),
    .effSrc     (effSel),
    .ready      (ready),
    .irqEn      (irqEn)
  );

  mclk_datapath #(
    .PRES_W       (PRES_W),
    .MAX_CODE     (MAX_CODE),
    .SETTLE_TICKS (SETTLE_TICKS)
  ) i_datapath (
    .clk        (clk),
    .rstN       (rstN),
    .srcTick    (srcTick),
    .effSrc     (effSel),
    .cfgPres    (cfgPres),
    .strb       (strb),
    .clkEn      (clkEn),
    .settleIdle (settleIdle)
  );

  assign effSrc = effSel;
  assign irq    = ready && irqEn;

endmodule

// File: tb/test_mclk_selector.sv
module test_mclk_selector;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [3:0] srcTick;
  logic       wrEn = 1'b0;
  logic [1:0] wrSrc = 2'd0;
  logic [2:0] wrPres = 3'd0;
  logic       wrIrqEn = 1'b0;
  logic       pllALock = 1'b1;
  logic       pllBLock = 1'b1;
  logic       clkEn, ready, irq;
  logic [1:0] effSrc;

  logic [3:0] tickMask = 4'hF;
  logic       sparse = 1'b0;
  logic       phase = 1'b0;
  int         nChecks = 0;
  int         nFails = 0;
  int         cycles = 0;

  always #2 clk = ~clk;
  always @(posedge clk) phase <= ~phase;
  assign srcTick = tickMask & (sparse ? {4{phase}} : 4'hF);

  mclk_selector i_mclk_selector (
    .clk(clk), .rstN(rstN), .srcTick(srcTick), .wrEn(wrEn), .wrSrc(wrSrc),
    .wrPres(wrPres), .wrIrqEn(wrIrqEn), .pllALock(pllALock), .pllBLock(pllBLock),
    .clkEn(clkEn), .ready(ready), .irq(irq), .effSrc(effSrc)
  );

  // {src[15:14], pres[13:11], mask[10:7], expected pulses in 64 cycles[6:0]}
  localparam logic [15:0] VECS [9] = '{
    {2'd1, 3'd0, 4'b1111, 7'd64},
    {2'd1, 3'd2, 4'b1111, 7'd16},
    {2'd2, 3'd3, 4'b1111, 7'd8},
    {2'd3, 3'd6, 4'b1111, 7'd1},
    {2'd3, 3'd7, 4'b1111, 7'd64},
    {2'd0, 3'd1, 4'b0001, 7'd32},
    {2'd0, 3'd4, 4'b1110, 7'd0},
    {2'd2, 3'd5, 4'b0100, 7'd2},
    {2'd1, 3'd1, 4'b0010, 7'd32}
  };

  task automatic summary();
    $display("  %0d/%0d checks passed", nChecks - nFails, nChecks);
  endtask

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic doWrite(input logic [1:0] s, input logic [2:0] p, input logic ie);
    @(negedge clk);
    wrEn = 1'b1; wrSrc = s; wrPres = p; wrIrqEn = ie;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic waitReady();
    for (int i = 0; i < 100 && !ready; i++) @(negedge clk);
  endtask

  task automatic countPulses(input int n, output int cnt);
    cnt = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (clkEn) cnt++;
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
      summary();
      $finish;
    end
  end

  initial begin
    int cnt;
    bit allHigh;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R10 reset state
    chk(ready == 1'b1, "R10 ready after reset", ready, 1);
    chk(effSrc == 2'd0, "R10 source after reset", effSrc, 0);
    chk(irq == 1'b0, "R10 irq after reset", irq, 0);
    countPulses(16, cnt);
    chk(cnt == 16, "R10 default divide by 1", cnt, 16);

    // R1 R2 table walk
    for (int v = 0; v < 9; v++) begin
      tickMask = 4'hF;
      doWrite(VECS[v][15:14], VECS[v][13:11], 1'b0);
      waitReady();
      chk(ready == 1'b1, "R3 ready after settle", ready, 1);
      chk(effSrc == VECS[v][15:14], "R1 effective source", effSrc, VECS[v][15:14]);
      @(negedge clk);
      tickMask = VECS[v][10:7];
      countPulses(64, cnt);
      chk(cnt == VECS[v][6:0], "R2 pulse count", cnt, VECS[v][6:0]);
    end
    tickMask = 4'hF;

    // R3 exact settle timing with continuous ticks
    doWrite(2'd3, 3'd1, 1'b0);
    chk(ready == 1'b0, "R3 ready cleared on write edge", ready, 0);
    repeat (2) @(negedge clk);
    chk(ready == 1'b0, "R3 ready low after 2 ticks", ready, 0);
    @(negedge clk);
    chk(ready == 1'b0, "R3 ready low after 3 ticks", ready, 0);
    @(negedge clk);
    chk(ready == 1'b1, "R3 ready high after 4 ticks", ready, 1);

    // R3 sparse ticks stretch the settle time
    sparse = 1'b1;
    doWrite(2'd1, 3'd0, 1'b0);
    repeat (5) @(negedge clk);
    chk(ready == 1'b0, "R3 sparse ticks still settling", ready, 0);
    repeat (3) @(negedge clk);
    chk(ready == 1'b1, "R3 sparse ticks settled", ready, 1);
    sparse = 1'b0;

    // R3 only ticks of the new source count
    tickMask = 4'b1101;
    doWrite(2'd1, 3'd2, 1'b0);
    repeat (20) @(negedge clk);
    chk(ready == 1'b0, "R3 no ticks of selected source", ready, 0);
    tickMask = 4'hF;
    waitReady();
    chk(ready == 1'b1, "R3 ready once ticks resume", ready, 1);

    // R4 same-value write, R9 irq enable
    doWrite(2'd1, 3'd2, 1'b1);
    allHigh = 1'b1;
    for (int i = 0; i < 8; i++) begin
      if (!ready) allHigh = 1'b0;
      @(negedge clk);
    end
    chk(allHigh, "R4 ready kept on unchanged write", allHigh, 1);
    chk(irq == 1'b1, "R9 irq with enable", irq, 1);
    countPulses(64, cnt);
    chk(cnt == 16, "R4 rate unchanged", cnt, 16);
    doWrite(2'd1, 3'd2, 1'b0);
    chk(irq == 1'b0 && ready == 1'b1, "R9 irq masked", irq, 0);
    doWrite(2'd1, 3'd3, 1'b1);
    chk(irq == 1'b0, "R9 irq low while settling", irq, 0);
    waitReady();
    chk(irq == 1'b1, "R9 irq after settle", irq, 1);

    // R5 PLL A fallback, R7 return
    doWrite(2'd2, 3'd0, 1'b1);
    waitReady();
    chk(effSrc == 2'd2 && ready, "R5 PLL A active", effSrc, 2);
    pllALock = 1'b0;
    @(negedge clk);
    chk(effSrc == 2'd0, "R5 fallback to slow", effSrc, 0);
    chk(ready == 1'b0 && irq == 1'b0, "R5 ready dropped", ready, 0);
    tickMask = 4'b0001;
    countPulses(16, cnt);
    chk(cnt == 16, "R5 pulses from slow ticks", cnt, 16);
    tickMask = 4'b0100;
    countPulses(16, cnt);
    chk(cnt == 0, "R5 PLL A ticks ignored", cnt, 0);
    chk(ready == 1'b0, "R5 ready held low while unlocked", ready, 0);
    tickMask = 4'hF;
    pllALock = 1'b1;
    @(negedge clk);
    chk(effSrc == 2'd2 && !ready, "R7 back to PLL A", effSrc, 2);
    repeat (3) @(negedge clk);
    chk(ready == 1'b0, "R7 settling after relock", ready, 0);
    @(negedge clk);
    chk(ready == 1'b1, "R7 ready after 4 PLL ticks", ready, 1);

    // R6 PLL B fallback
    doWrite(2'd3, 3'd0, 1'b0);
    waitReady();
    pllBLock = 1'b0;
    @(negedge clk);
    chk(effSrc == 2'd1, "R6 fallback to main", effSrc, 1);
    tickMask = 4'b0010;
    countPulses(16, cnt);
    chk(cnt == 16, "R6 pulses from main ticks", cnt, 16);
    chk(ready == 1'b0, "R6 ready held low", ready, 0);
    tickMask = 4'hF;
    pllBLock = 1'b1;
    waitReady();
    chk(effSrc == 2'd3 && ready, "R7 back to PLL B", effSrc, 3);

    // R8 unselected PLL losing lock
    doWrite(2'd1, 3'd0, 1'b0);
    waitReady();
    pllALock = 1'b0;
    pllBLock = 1'b0;
    allHigh = 1'b1;
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      if (!ready || effSrc != 2'd1) allHigh = 1'b0;
    end
    chk(allHigh, "R8 no effect of foreign unlock", allHigh, 1);
    pllALock = 1'b1;
    pllBLock = 1'b1;

    summary();
    $finish;
  end

endmodule